// File: doc/BRIEF.md
# Edge-Timed Serial Bit Recovery

This block recovers bits from a serial line whose coding keeps transitions frequent: any 5 consecutive bits contain at least one change, and up to 5 changes can occur in that span. It runs on a system clock that oversamples the line by `BIT_CYC` cycles per nominal bit. An upstream detector signals with a one-cycle start pulse that a frame has begun and that the line is at a bit boundary. From then on the block counts down a bit timer and samples the line each time the timer runs out. It delivers each sample on `bit_o` together with a one-cycle `bit_vld_o` strobe. Sampling stops when the end-of-frame input is asserted.

The timer is not fixed. During each bit window the block notes the cycle in which the first synchronized line change appears, relative to the boundary it predicted. That offset, the lag, is clamped to a quarter of a bit and added to the nominal period for the next reload. The sample point therefore follows a transmitter whose bit period drifts a little away from nominal. A window that contains no change leaves the next period at nominal.

Top module: `bit_recovery`

## Requirements
- R1: From reset until the first start pulse, `bit_vld_o` and `bit_o` stay 0 whatever `line_i` does.
- R2: Let the start-registering edge be the rising edge at which `sync_start_i` is high. The first `bit_vld_o` after a start appears on the `BIT_CYC/2`-th rising edge after it.
- R3: `bit_vld_o` is high for exactly one cycle per sample. While it is high, `bit_o` equals the value `line_i` had at the rising edge two edges before the edge that raised the strobe, because the line passes a two-flop synchronizer.
- R4: After each sample the timer reloads with `BIT_CYC + lag`. Consecutive strobes are therefore between `BIT_CYC - BIT_CYC/4` and `BIT_CYC + BIT_CYC/4` cycles apart.
- R5: Count the strobe cycle as cycle 0. A change driven on `line_i` in cycle j of that window gives a raw lag of `j + 2 - (BIT_CYC - BIT_CYC/2)`, and this raw lag sets the gap between the next two strobes. For the first window, the predicted boundary is the cycle after the start-registering edge.
- R6: The lag is clamped to the range `-BIT_CYC/4 .. +BIT_CYC/4`.
- R7: A window with no line change gives lag 0, so the next gap is exactly `BIT_CYC`. When a window contains several changes, only the first one sets the lag.
- R8: Once `frame_end_i` is registered, no strobe occurs until the next start pulse. A start pulse in the same cycle overrides the end-of-frame input.
- R9: A frame sent with a bit period that drifts by one cycle every fourth bit, either longer or shorter, is recovered bit-exact.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Oversampling system clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously |
| line_i | input | 1 | Raw serial line |
| sync_start_i | input | 1 | One-cycle pulse: frame start detected, line at a bit boundary |
| frame_end_i | input | 1 | End of frame, stops sampling |
| bit_o | output | 1 | Recovered bit value |
| bit_vld_o | output | 1 | One-cycle strobe marking a new `bit_o` |

## Verification
A wrong lag value or a stuck edge-seen flag shows at the ports as a strobe gap that is off by one or more cycles. It appears one window after the faulty measurement, so a gap check catches it within two bit periods. A timer or phase counter that drifts the wrong way stays hidden for a few bits. It then shows as a wrong `bit_o` once the sample point reaches a line change, and a drifting frame makes this happen inside a few dozen bits. The bench model runs in step with the design on every clock, so any such divergence is flagged in the first cycle it reaches `bit_vld_o` or `bit_o`.

// File: rtl/btr_pkg.sv
package btr_pkg;

  typedef enum logic {
    RX_IDLE = 1'b0,
    RX_RUN  = 1'b1
  } rx_state_e;

  // Clamp a signed offset to +/- lim.
  function automatic int clamp_lag(int v, int lim);
    if (v > lim) begin
      return lim;
    end else if (v < -lim) begin
      return -lim;
    end
    return v;
  endfunction

endpackage

// File: rtl/btr_line_sync.sv
module btr_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  output logic line_s_o,
  output logic edge_o
);

  // pipe_q[STAGES-1:0] is the synchronizer chain, pipe_q[STAGES] the
  // one-cycle-old copy of the synchronized line used for edge detection.
  logic [STAGES:0] pipe_q;
  logic [STAGES:0] pipe_d;

  always_comb begin
    pipe_d = {pipe_q[STAGES-1:0], line_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pipe_q <= '0;
    end else begin
      pipe_q <= pipe_d;
    end
  end

  assign line_s_o = pipe_q[STAGES-1];
  assign edge_o   = pipe_q[STAGES] ^ pipe_q[STAGES-1];

endmodule

// File: rtl/btr_bit_timer.sv
module btr_bit_timer #(
  parameter int BIT_CYC = 16,
  parameter int LAG_W   = 4
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    run_i,
  input  logic                    start_i,
  input  logic                    eof_i,
  input  logic signed [LAG_W-1:0] lag_i,
  output logic                    expire_o
);

  localparam int LAG_MAX  = BIT_CYC / 4;
  localparam int HALF_DN  = BIT_CYC / 2;
  localparam int CNT_W    = $clog2(BIT_CYC + LAG_MAX + 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;
  logic             active;

  assign active   = run_i & ~start_i & ~eof_i;
  assign expire_o = active & (cnt_q == CNT_W'(1));

  // Next-state: half period on start, nominal plus lag on expiry,
  // otherwise count down.
  always_comb begin
    cnt_en = start_i | active;
    cnt_d  = cnt_q;
    if (start_i) begin
      cnt_d = CNT_W'(HALF_DN);
    end else if (expire_o) begin
      cnt_d = CNT_W'(BIT_CYC + int'(lag_i));
    end else if (active) begin
      cnt_d = cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  // R4: every reload lands inside the nominal period +/- the lag bound.
  p_reload_range_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_o |=> ((cnt_q >= CNT_W'(BIT_CYC - LAG_MAX)) &&
                  (cnt_q <= CNT_W'(BIT_CYC + LAG_MAX))));

  // R4: between reloads the timer steps down by one each cycle.
  p_count_down_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active && !expire_o) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));

  // R2: a start pulse reloads the half-bit delay.
  p_half_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (cnt_q == CNT_W'(HALF_DN)));

endmodule

// File: rtl/btr_lag_meter.sv
module btr_lag_meter
  import btr_pkg::*;
#(
  parameter int BIT_CYC = 16,
  parameter int LAG_W   = 4
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    run_i,
  input  logic                    start_i,
  input  logic                    eof_i,
  input  logic                    expire_i,
  input  logic                    edge_i,
  output logic signed [LAG_W-1:0] lag_o
);

  localparam int LAG_MAX = BIT_CYC / 4;
  localparam int HALF_UP = BIT_CYC - BIT_CYC / 2;
  localparam int PH_W    = $clog2(BIT_CYC) + 3;

  // Phase: cycles since the predicted bit boundary (negative before it).
  logic signed [PH_W-1:0]  phase_q, phase_d;
  logic                    seen_q,  seen_d;
  logic signed [LAG_W-1:0] lag_q,   lag_d;
  logic                    active;
  logic                    first_edge;
  logic                    upd_en;
  logic signed [LAG_W-1:0] meas;

  assign active     = run_i & ~start_i & ~eof_i;
  assign first_edge = active & edge_i & ~seen_q;
  assign meas       = LAG_W'(clamp_lag(int'(phase_q), LAG_MAX));

  // Lag offered to the timer: the stored first-edge offset, or an edge
  // arriving in the expiry cycle itself, or zero for an edgeless window.
  always_comb begin
    if (seen_q) begin
      lag_o = lag_q;
    end else if (first_edge) begin
      lag_o = meas;
    end else begin
      lag_o = '0;
    end
  end

  always_comb begin
    upd_en  = start_i | active;
    phase_d = phase_q;
    seen_d  = seen_q;
    lag_d   = lag_q;
    if (start_i) begin
      phase_d = '0;
      seen_d  = 1'b0;
      lag_d   = '0;
    end else if (expire_i) begin
      phase_d = PH_W'(-HALF_UP);
      seen_d  = 1'b0;
    end else if (active) begin
      phase_d = phase_q + PH_W'(1);
      if (first_edge) begin
        seen_d = 1'b1;
        lag_d  = meas;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= '0;
      seen_q  <= 1'b0;
      lag_q   <= '0;
    end else if (upd_en) begin
      phase_q <= phase_d;
      seen_q  <= seen_d;
      lag_q   <= lag_d;
    end
  end

  // R6: the lag handed to the timer never leaves the clamp range.
  p_lag_bound_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> ((int'(lag_o) <= LAG_MAX) && (int'(lag_o) >= -LAG_MAX)));

  // R7: once a window has its first edge, later edges leave it alone.
  p_first_edge_only_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active && seen_q && !expire_i) |=> $stable(lag_q));

endmodule

// File: rtl/bit_recovery.sv
module bit_recovery
  import btr_pkg::*;
#(
  parameter int BIT_CYC     = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  input  logic sync_start_i,
  input  logic frame_end_i,
  output logic bit_o,
  output logic bit_vld_o
);

  localparam int LAG_MAX = BIT_CYC / 4;
  localparam int LAG_W   = $clog2(LAG_MAX + 1) + 1;

  rx_state_e               state_q, state_d;
  logic                    run;
  logic                    line_s;
  logic                    line_edge;
  logic                    expire;
  logic signed [LAG_W-1:0] lag;
  logic                    bit_q, bit_d, bit_en;
  logic                    vld_q, vld_d;

  btr_line_sync #(
    .STAGES (SYNC_STAGES)
  ) sync_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .line_i   (line_i),
    .line_s_o (line_s),
    .edge_o   (line_edge)
  );

  btr_lag_meter #(
    .BIT_CYC (BIT_CYC),
    .LAG_W   (LAG_W)
  ) lag_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (run),
    .start_i  (sync_start_i),
    .eof_i    (frame_end_i),
    .expire_i (expire),
    .edge_i   (line_edge),
    .lag_o    (lag)
  );

  btr_bit_timer #(
    .BIT_CYC (BIT_CYC),
    .LAG_W   (LAG_W)
  ) timer_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (run),
    .start_i  (sync_start_i),
    .eof_i    (frame_end_i),
    .lag_i    (lag),
    .expire_o (expire)
  );

  assign run = (state_q == RX_RUN);

  // Run control: start wins over end of frame.
  always_comb begin
    state_d = state_q;
    if (sync_start_i) begin
      state_d = RX_RUN;
    end else if (frame_end_i) begin
      state_d = RX_IDLE;
    end
  end

  always_comb begin
    vld_d  = expire;
    bit_en = expire;
    bit_d  = line_s;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= RX_IDLE;
      vld_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      vld_q   <= vld_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_q <= 1'b0;
    end else if (bit_en) begin
      bit_q <= bit_d;
    end
  end

  assign bit_o     = bit_q;
  assign bit_vld_o = vld_q;

  // R3: a strobe never lasts longer than one cycle.
  p_strobe_pulse_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_vld_o |=> !bit_vld_o);

  // R8: end of frame silences the next cycle unless a start overrides it.
  p_eof_silence_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_end_i && !sync_start_i) |=> !bit_vld_o);

  // R1: while idle and not started, no strobe follows.
  p_idle_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run && !sync_start_i) |=> !bit_vld_o);

endmodule

// File: tb/bit_recovery_tb_top.sv
module bit_recovery_tb_top;

  localparam int T       = 16;
  localparam int LMAX    = T / 4;
  localparam int HUP     = T - T / 2;
  localparam int WDOG    = 100000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic line = 1'b0;
  logic start = 1'b0;
  logic eof = 1'b0;
  logic bit_o, bit_vld_o;

  int vectors = 0;
  int miscompares = 0;
  int cyc = 0;
  bit done = 1'b0;
  bit log_en = 1'b0;
  bit rx_b[$];
  int rx_t[$];

  always #4 clk = ~clk;  // 125 MHz

  bit_recovery #(.BIT_CYC(T)) dut_i (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .line_i       (line),
    .sync_start_i (start),
    .frame_end_i  (eof),
    .bit_o        (bit_o),
    .bit_vld_o    (bit_vld_o)
  );

  function automatic int sat(int v);
    if (v > LMAX) return LMAX;
    if (v < -LMAX) return -LMAX;
    return v;
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  bit m_run, m_seen, m_vld, m_bit, m_f1, m_s, m_sq;
  int m_cnt, m_ph, m_lag;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_run = 0; m_seen = 0; m_vld = 0; m_bit = 0;
      m_f1 = 0; m_s = 0; m_sq = 0;
      m_cnt = 0; m_ph = 0; m_lag = 0;
    end else begin
      bit e, first;
      int use_lag;
      e = (m_s != m_sq);
      if (start) begin
        m_run = 1; m_cnt = T / 2; m_ph = 0; m_seen = 0; m_lag = 0; m_vld = 0;
      end else if (eof) begin
        m_run = 0; m_vld = 0;
      end else if (m_run) begin
        first = e && !m_seen;
        if (m_cnt == 1) begin
          use_lag = m_seen ? m_lag : (first ? sat(m_ph) : 0);
          m_vld = 1; m_bit = m_s;
          m_cnt = T + use_lag; m_ph = -HUP; m_seen = 0;
        end else begin
          m_vld = 0;
          if (first) begin m_seen = 1; m_lag = sat(m_ph); end
          m_cnt = m_cnt - 1; m_ph = m_ph + 1;
        end
      end else begin
        m_vld = 0;
      end
      m_sq = m_s; m_s = m_f1; m_f1 = line;
    end
  end

  always @(posedge clk) cyc <= cyc + 1;

  // Cycle-by-cycle comparison against the model (R3, R5, R6, R7).
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(bit_vld_o == m_vld, "R3 strobe vs model", bit_vld_o, m_vld);
      if (m_vld) chk(bit_o == m_bit, "R3 bit vs model", bit_o, m_bit);
    end
    if (log_en && bit_vld_o) begin
      rx_b.push_back(bit_o);
      rx_t.push_back(cyc);
    end
  end

  always @(posedge clk) begin
    if (cyc > WDOG && !done) begin
      done = 1;
      miscompares++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, WDOG);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  task automatic wait_vld();
    do @(negedge clk); while (!bit_vld_o);
  endtask

  // Edges driven at offsets j1/j2 of one window; the gap between the two
  // following strobes must be T plus the clamped first-edge lag.
  task automatic gap_test(int j1, int j2, string tag);
    int tb, tc, expg;
    wait_vld();
    for (int k = 0; k < 15; k++) begin
      if (k == j1 || k == j2) line = ~line;
      @(negedge clk);
    end
    wait_vld(); tb = cyc;
    wait_vld(); tc = cyc;
    expg = (j1 < 0) ? T : T + sat(j1 + 2 - HUP);
    chk((tc - tb) == expg, tag, tc - tb, expg);
  endtask

  task automatic run_frame(int n, int slow, string tag);
    bit tx[$];
    int lf, run_len, len;
    bit b, prev;
    rx_b.delete(); rx_t.delete();
    lf = 7'h5B; prev = 0; run_len = 0;
    for (int i = 0; i < n; i++) begin
      lf = ((lf << 1) | (((lf >> 6) ^ (lf >> 5)) & 1)) & 7'h7F;
      b = lf[0];
      if (i == 0) b = 1;
      else if (b == prev && run_len >= 4) b = ~prev;
      run_len = (i == 0 || b != prev) ? 1 : run_len + 1;
      prev = b;
      tx.push_back(b);
    end
    log_en = 1;
    for (int i = 0; i < n; i++) begin
      line = tx[i];
      len = T + ((i % 4 == 3) ? slow : 0);
      for (int c = 0; c < len; c++) begin
        start = (i == 0 && c == 1);
        @(negedge clk);
      end
    end
    start = 0;
    repeat (4) @(negedge clk);
    eof = 1; @(negedge clk); eof = 0;
    log_en = 0;
    chk(rx_b.size() >= n, {tag, " R9 bit count"}, rx_b.size(), n);
    for (int i = 0; i < n && i < rx_b.size(); i++)
      chk(rx_b[i] == tx[i], {tag, " R9 recovered bit"}, rx_b[i], tx[i]);
    for (int i = 1; i < rx_t.size(); i++) begin
      int g;
      g = rx_t[i] - rx_t[i-1];
      chk(g >= T - LMAX && g <= T + LMAX, {tag, " R4 strobe spacing"}, g, T);
    end
  endtask

  initial begin
    int k;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: no output activity before a start, line toggling.
    for (int i = 0; i < 20; i++) begin
      if (i % 3 == 0) line = ~line;
      @(negedge clk);
      chk(bit_vld_o == 0, "R1 strobe idle", bit_vld_o, 0);
      chk(bit_o == 0, "R1 bit idle", bit_o, 0);
    end
    line = 0;
    repeat (6) @(negedge clk);
    // R2: first strobe T/2 edges after the start-registering edge.
    start = 1; @(negedge clk); start = 0;
    k = 1;
    while (!bit_vld_o && k < 40) begin @(negedge clk); k++; end
    chk(k == T / 2 + 1, "R2 first strobe delay", k, T / 2 + 1);
    // R5/R6/R7: gap after a window with controlled edges.
    gap_test(-1, -1, "R7 no-edge window");
    gap_test(12, -1, "R6 late edge clamped");
    gap_test(0, -1, "R6 early edge clamped");
    gap_test(3, -1, "R5 early edge");
    gap_test(10, -1, "R5 late edge");
    gap_test(3, 5, "R7 first of two edges");
    // R8: end of frame silences the strobe.
    eof = 1; @(negedge clk); eof = 0;
    k = 0;
    for (int i = 0; i < 60; i++) begin
      if (i % 5 == 0) line = ~line;
      @(negedge clk);
      if (bit_vld_o) k++;
    end
    chk(k == 0, "R8 strobes after end of frame", k, 0);
    line = 0;
    repeat (20) @(negedge clk);
    // R9: drifting frames, restarted after end of frame (R8).
    run_frame(64, 1, "slow");
    line = 0;
    repeat (20) @(negedge clk);
    run_frame(64, -1, "fast");
    repeat (5) @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule